// File: doc/BRIEF.md
# Phase-Accumulating Waveform Table Reader

This block is the digital core of a direct digital synthesis generator. A wide phase register adds a programmable step on every clock. The most significant bits of the new phase address a table in an external SRAM that holds exactly one period of the wanted waveform. The sample that comes back is registered onto a parallel converter bus together with a one-cycle strobe. Because each wrap of the phase register finishes one period, the output frequency is `step × f_clk / 2^PHASE_W`.

The SRAM is shared with a separate table loader. The reader raises a request while it is generating, and a read only happens in a cycle where the grant is also high. A missed read produces no strobe, but the phase keeps advancing so that the frequency is preserved. Generation does not start until the loader signals that the table is complete, and the phase is held at zero until then.

A new step value goes into a staging register first. It only becomes the active step at a phase wrap, or at once while the generator is not running, so a retune never cuts a period short.

Top module: `dds_wave_reader`

## Requirements
- R1: While `rst` is high at a clock edge, every output is cleared after that edge: `sram_addr`=0, `sram_req`=0, `dac_strobe`=0, `dac_data`=0. The active step and the staged step are also cleared.
- R2: At every edge where `table_ready` is low, the phase is set to zero and `sram_req` goes low, so `sram_addr` reads 0 after that edge. Dropping `table_ready` while running clears the phase the same way.
- R3: At every edge where `table_ready` and `gen_enable` are both high, the phase becomes the old phase plus the active step, modulo 2^PHASE_W. After that edge `sram_addr` equals phase bits [PHASE_W-1 : PHASE_W-ADDR_W] and `sram_req` is high.
- R4: At an edge where `table_ready` is high and `gen_enable` is low, the phase holds its value and `sram_req` goes low.
- R5: A word presented with `freq_load` high at an edge where the generator is not running (either `table_ready` or `gen_enable` low) becomes the active step at the next edge where the generator is not running or where the phase wraps.
- R6: While the generator is running, a staged word becomes active only at the addition that carries out of the phase register. That addition still uses the old step, and the new step applies from the next addition.
- R7: A read is issued in each cycle where `sram_req` and `sram_gnt` are both high. The SRAM returns the word for that address on `sram_rdata` one cycle later. `dac_data` shows that word, with `dac_strobe` high, two cycles after the address cycle.
- R8: Two cycles after a cycle without a granted read, `dac_strobe` is low and `dac_data` keeps its previous value.
- R9: With a constant step K, the phase wraps exactly once every 2^PHASE_W / K running clocks. For example, K = 2^28 with PHASE_W = 32 gives four wraps in 64 clocks.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst | input | 1 | Synchronous active-high reset |
| freq_word | input | PHASE_W | Phase step to stage |
| freq_load | input | 1 | Writes `freq_word` into the staging register |
| gen_enable | input | 1 | Runs the phase register when high |
| table_ready | input | 1 | Loader has finished the table; phase held at zero while low |
| sram_req | output | 1 | Reader wants the SRAM this cycle |
| sram_gnt | input | 1 | Arbiter grants the SRAM to the reader |
| sram_addr | output | ADDR_W | Table read address (top phase bits) |
| sram_rdata | input | SAMPLE_W | Word returned one cycle after a granted address |
| dac_data | output | SAMPLE_W | Registered sample for the converter |
| dac_strobe | output | 1 | High for one cycle with each new sample |

## Verification
A corrupted phase register or active step shows up on `sram_addr` immediately after the next edge, because the address is taken straight from the phase register. A bad step commit only shows up at the first wrap after a load, so the bench retunes in the middle of a period and checks the address sequence around the carry. A fault in the read pipeline appears two cycles after the address cycle, as a missing, extra or misaligned strobe, or as a `dac_data` value that does not match the pattern returned for that address. A missed grant is visible as a strobe gap at the same offset.

// File: rtl/dds_pkg.sv
`timescale 1ns/1ps
package dds_pkg;

  // default geometry: 32-bit phase, 256K-word table of 16-bit samples
  parameter int unsigned DEF_PHASE_W  = 32;
  parameter int unsigned DEF_ADDR_W   = 18;
  parameter int unsigned DEF_SAMPLE_W = 16;
  parameter int unsigned DEF_SRAM_LAT = 1;

  // run state of the phase register
  typedef enum logic [1:0] {
    PH_IDLE  = 2'd0,   // table not ready, phase forced to zero
    PH_PAUSE = 2'd1,   // table ready, enable low, phase held
    PH_RUN   = 2'd2    // phase advancing
  } ph_mode_e;

  function automatic ph_mode_e decode_mode(input logic ready, input logic enable);
    if (!ready)       return PH_IDLE;
    else if (!enable) return PH_PAUSE;
    else              return PH_RUN;
  endfunction

endpackage

// File: rtl/dds_freq_buffer.sv
`timescale 1ns/1ps
module dds_freq_buffer #(
  parameter int unsigned WORD_W = 32
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              load_i,
  input  logic [WORD_W-1:0] word_i,
  input  logic              commit_i,
  output logic [WORD_W-1:0] step_o
);

  logic [WORD_W-1:0] stage_q;
  logic              stage_vld_q;
  logic [WORD_W-1:0] active_q;

  // staging register; a load in a commit cycle keeps the new word pending
  always_ff @(posedge clk) begin
    if (rst) begin
      stage_q     <= '0;
      stage_vld_q <= 1'b0;
    end else if (load_i) begin
      stage_q     <= word_i;
      stage_vld_q <= 1'b1;
    end else if (commit_i) begin
      stage_vld_q <= 1'b0;
    end
  end

  // active step only changes on a commit with a pending word
  always_ff @(posedge clk) begin
    if (rst) begin
      active_q <= '0;
    end else if (commit_i && stage_vld_q) begin
      active_q <= stage_q;
    end
  end

  assign step_o = active_q;

endmodule

// File: rtl/dds_phase_acc.sv
`timescale 1ns/1ps
module dds_phase_acc
  import dds_pkg::*;
#(
  parameter int unsigned PHASE_W = 32
) (
  input  logic               clk,
  input  logic               rst,
  input  logic               ready_i,
  input  logic               enable_i,
  input  logic [PHASE_W-1:0] step_i,
  output logic [PHASE_W-1:0] phase_o,
  output logic               run_o,
  output logic               wrap_o,
  output logic               commit_o
);

  logic [PHASE_W-1:0] phase_q;
  logic               run_q;
  logic [PHASE_W:0]   sum_w;
  ph_mode_e           mode_w;

  assign mode_w = decode_mode(ready_i, enable_i);
  assign sum_w  = {1'b0, phase_q} + {1'b0, step_i};

  // carry out of the addition that happens this cycle
  assign wrap_o   = (mode_w == PH_RUN) && sum_w[PHASE_W];
  // step may change at a wrap, or freely while not running
  assign commit_o = (mode_w != PH_RUN) || sum_w[PHASE_W];

  always_ff @(posedge clk) begin
    if (rst) begin
      phase_q <= '0;
      run_q   <= 1'b0;
    end else begin
      unique case (mode_w)
        PH_IDLE: begin
          phase_q <= '0;
          run_q   <= 1'b0;
        end
        PH_PAUSE: begin
          run_q   <= 1'b0;
        end
        default: begin
          phase_q <= sum_w[PHASE_W-1:0];
          run_q   <= 1'b1;
        end
      endcase
    end
  end

  assign phase_o = phase_q;
  assign run_o   = run_q;

endmodule

// File: rtl/dds_read_pipe.sv
`timescale 1ns/1ps
module dds_read_pipe #(
  parameter int unsigned SAMPLE_W = 16,
  parameter int unsigned SRAM_LAT = 1
) (
  input  logic                clk,
  input  logic                rst,
  input  logic                issue_i,
  input  logic [SAMPLE_W-1:0] rdata_i,
  output logic [SAMPLE_W-1:0] sample_o,
  output logic                strobe_o
);

  // valid bit follows the read through the SRAM latency
  logic [SRAM_LAT-1:0] vld_q;

  genvar g;
  generate
    for (g = 0; g < SRAM_LAT; g++) begin : g_vld
      if (g == 0) begin : g_head
        always_ff @(posedge clk) begin
          if (rst) vld_q[g] <= 1'b0;
          else     vld_q[g] <= issue_i;
        end
      end else begin : g_tail
        always_ff @(posedge clk) begin
          if (rst) vld_q[g] <= 1'b0;
          else     vld_q[g] <= vld_q[g-1];
        end
      end
    end
  endgenerate

  logic                arrive_w;
  logic [SAMPLE_W-1:0] sample_q;
  logic                strobe_q;

  assign arrive_w = vld_q[SRAM_LAT-1];

  always_ff @(posedge clk) begin
    if (rst) begin
      sample_q <= '0;
      strobe_q <= 1'b0;
    end else begin
      strobe_q <= arrive_w;
      if (arrive_w) sample_q <= rdata_i;
    end
  end

  assign sample_o = sample_q;
  assign strobe_o = strobe_q;

endmodule

// File: rtl/dds_wave_reader.sv
`timescale 1ns/1ps
module dds_wave_reader
  import dds_pkg::*;
#(
  parameter int unsigned PHASE_W  = DEF_PHASE_W,
  parameter int unsigned ADDR_W   = DEF_ADDR_W,
  parameter int unsigned SAMPLE_W = DEF_SAMPLE_W,
  parameter int unsigned SRAM_LAT = DEF_SRAM_LAT
) (
  input  logic                clk,
  input  logic                rst,
  input  logic [PHASE_W-1:0]  freq_word,
  input  logic                freq_load,
  input  logic                gen_enable,
  input  logic                table_ready,
  output logic                sram_req,
  input  logic                sram_gnt,
  output logic [ADDR_W-1:0]   sram_addr,
  input  logic [SAMPLE_W-1:0] sram_rdata,
  output logic [SAMPLE_W-1:0] dac_data,
  output logic                dac_strobe
);

  localparam int unsigned ADDR_LSB = PHASE_W - ADDR_W;

  logic [PHASE_W-1:0] step_w;
  logic [PHASE_W-1:0] phase_w;
  logic               run_w;
  logic               wrap_w;
  logic               commit_w;
  logic               issue_w;

  dds_freq_buffer #(.WORD_W(PHASE_W)) u_freq (
    .clk      (clk),
    .rst      (rst),
    .load_i   (freq_load),
    .word_i   (freq_word),
    .commit_i (commit_w),
    .step_o   (step_w)
  );

  dds_phase_acc #(.PHASE_W(PHASE_W)) u_phase (
    .clk      (clk),
    .rst      (rst),
    .ready_i  (table_ready),
    .enable_i (gen_enable),
    .step_i   (step_w),
    .phase_o  (phase_w),
    .run_o    (run_w),
    .wrap_o   (wrap_w),
    .commit_o (commit_w)
  );

  // request and address come straight from registers
  assign sram_req  = run_w;
  assign sram_addr = phase_w[PHASE_W-1:ADDR_LSB];
  assign issue_w   = run_w && sram_gnt;

  dds_read_pipe #(.SAMPLE_W(SAMPLE_W), .SRAM_LAT(SRAM_LAT)) u_read (
    .clk      (clk),
    .rst      (rst),
    .issue_i  (issue_w),
    .rdata_i  (sram_rdata),
    .sample_o (dac_data),
    .strobe_o (dac_strobe)
  );

  logic unused_w;
  assign unused_w = wrap_w;

endmodule

// File: rtl/dds_wave_reader_chk.sv
`timescale 1ns/1ps
module dds_wave_reader_chk #(
  parameter int unsigned ADDR_W   = 18,
  parameter int unsigned SAMPLE_W = 16
) (
  input logic                clk,
  input logic                rst,
  input logic                gen_enable,
  input logic                table_ready,
  input logic                sram_req,
  input logic                sram_gnt,
  input logic [ADDR_W-1:0]   sram_addr,
  input logic [SAMPLE_W-1:0] dac_data,
  input logic                dac_strobe
);

  // arms the history-based checks once enough edges follow reset
  logic [1:0] age_q;
  logic       armed;
  always_ff @(posedge clk) begin
    if (rst)               age_q <= '0;
    else if (age_q != 2'd3) age_q <= age_q + 2'd1;
  end
  assign armed = (age_q == 2'd3);

  p_idle_clear_r2: assert property (@(posedge clk) disable iff (rst)
    !table_ready |=> (sram_addr == '0) && !sram_req);

  p_pause_hold_r4: assert property (@(posedge clk) disable iff (rst || !armed)
    (table_ready && !gen_enable) |=> $stable(sram_addr) && !sram_req);

  p_run_req_r3: assert property (@(posedge clk) disable iff (rst)
    (table_ready && gen_enable) |=> sram_req);

  p_strobe_lat_r7: assert property (@(posedge clk) disable iff (rst)
    (sram_req && sram_gnt) |-> ##2 dac_strobe);

  p_no_strobe_r8: assert property (@(posedge clk) disable iff (rst)
    !(sram_req && sram_gnt) |-> ##2 !dac_strobe);

  p_data_hold_r8: assert property (@(posedge clk) disable iff (rst || !armed)
    !dac_strobe |-> $stable(dac_data));

endmodule

bind dds_wave_reader dds_wave_reader_chk #(
  .ADDR_W   (ADDR_W),
  .SAMPLE_W (SAMPLE_W)
) u_chk (
  .clk         (clk),
  .rst         (rst),
  .gen_enable  (gen_enable),
  .table_ready (table_ready),
  .sram_req    (sram_req),
  .sram_gnt    (sram_gnt),
  .sram_addr   (sram_addr),
  .dac_data    (dac_data),
  .dac_strobe  (dac_strobe)
);

// File: tb/test_dds_wave_reader.sv
`timescale 1ns/1ps
module test_dds_wave_reader;

  localparam int PW = 32;
  localparam int AW = 18;
  localparam int SW = 16;

  logic          clk = 1'b0;
  logic          rst = 1'b1;
  logic [PW-1:0] fw  = '0;
  logic          ld  = 1'b0;
  logic          en  = 1'b0;
  logic          rdy = 1'b0;
  logic          gnt = 1'b1;
  logic          sram_req;
  logic [AW-1:0] sram_addr;
  logic [SW-1:0] sram_rdata = '0;
  logic [SW-1:0] dac_data;
  logic          dac_strobe;

  always #5 clk = ~clk;

  dds_wave_reader #(.PHASE_W(PW), .ADDR_W(AW), .SAMPLE_W(SW), .SRAM_LAT(1)) i_dds_wave_reader (
    .clk(clk), .rst(rst), .freq_word(fw), .freq_load(ld), .gen_enable(en),
    .table_ready(rdy), .sram_req(sram_req), .sram_gnt(gnt), .sram_addr(sram_addr),
    .sram_rdata(sram_rdata), .dac_data(dac_data), .dac_strobe(dac_strobe)
  );

  function automatic logic [SW-1:0] pat(input logic [AW-1:0] a);
    return a[15:0] ^ {a[17:16], 14'h1A5C};
  endfunction

  // external SRAM: word valid the cycle after a granted address
  always @(posedge clk) begin
    if (sram_req && gnt) sram_rdata <= pat(sram_addr);
  end

  int total = 0;
  int bad   = 0;

  // reference state built from the requirements
  logic [PW-1:0] m_acc = '0, m_act = '0, m_pend = '0;
  logic          m_pv = 1'b0, m_run = 1'b0;
  logic          s1_v = 1'b0, e_strobe = 1'b0;
  logic [SW-1:0] s1_d = '0, e_dac = '0;

  task automatic chk(input bit ok, input string tag, input longint act, input longint exp);
    total++;
    if (!ok) begin
      bad++;
      $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
    end
  endtask

  task automatic tick(input string tag);
    logic          iss, cm;
    logic [SW-1:0] d;
    logic [PW:0]   sum;
    iss = m_run && gnt;
    d   = pat(m_acc[PW-1 -: AW]);
    cm  = 1'b0;
    if (rst) begin
      m_acc = '0; m_act = '0; m_pend = '0; m_pv = 0; m_run = 0;
      s1_v = 0; s1_d = '0; e_strobe = 0; e_dac = '0;
    end else begin
      if (!rdy) begin
        m_acc = '0; m_run = 0; cm = 1;
      end else if (en) begin
        sum = {1'b0, m_acc} + {1'b0, m_act};
        m_acc = sum[PW-1:0]; m_run = 1; cm = sum[PW];
      end else begin
        m_run = 0; cm = 1;
      end
      if (cm && m_pv) m_act = m_pend;
      if (ld) begin m_pend = fw; m_pv = 1; end
      else if (cm) m_pv = 0;
      e_strobe = s1_v;
      if (s1_v) e_dac = s1_d;
      s1_v = iss; s1_d = d;
    end
    @(posedge clk); #1;
    chk({sram_addr, sram_req, dac_strobe, dac_data} ==
        {m_acc[PW-1 -: AW], m_run, e_strobe, e_dac}, tag,
        {sram_addr, sram_req, dac_strobe, dac_data},
        {m_acc[PW-1 -: AW], m_run, e_strobe, e_dac});
  endtask

  task automatic t_reset();
    rst = 1'b1;
    repeat (3) tick("R1 reset state");
    chk(sram_addr == '0 && !sram_req && !dac_strobe && dac_data == '0, "R1 outputs zero",
        {sram_addr, sram_req, dac_strobe}, 0);
    rst = 1'b0;
  endtask

  task automatic t_idle();
    rdy = 1'b0; en = 1'b1;
    fw = 32'h1000_0000; ld = 1'b1; tick("R5 load while idle");
    ld = 1'b0;
    repeat (5) tick("R2 idle holds zero");
    chk(sram_addr == '0 && !sram_req, "R2 idle address", sram_addr, 0);
  endtask

  task automatic t_run();
    rdy = 1'b1; gnt = 1'b1;
    tick("R5 first step");
    chk(sram_addr == 18'h04000, "R5 step active on first add", sram_addr, 18'h04000);
    repeat (20) tick("R3 phase advance");
  endtask

  task automatic t_pause();
    logic [AW-1:0] held;
    en = 1'b0; tick("R4 pause");
    held = sram_addr;
    repeat (4) tick("R4 pause hold");
    chk(sram_addr == held && !sram_req, "R4 address held", sram_addr, held);
    en = 1'b1;
  endtask

  task automatic t_grant();
    logic [AW-1:0] a0;
    logic [SW-1:0] hold;
    gnt = 1'b0;
    repeat (2) tick("R8 no grant");
    hold = dac_data;
    repeat (3) tick("R8 no grant hold");
    chk(!dac_strobe && dac_data == hold, "R8 data held", dac_data, hold);
    gnt = 1'b1;
    a0 = sram_addr;
    tick("R7 latency"); tick("R7 latency");
    chk(dac_strobe && dac_data == pat(a0), "R7 two-cycle sample", dac_data, pat(a0));
    repeat (3) tick("R7 stream");
  endtask

  task automatic t_retune();
    rdy = 1'b0; tick("R2 clear");
    fw = 32'h4000_0000; ld = 1'b1; tick("R5 stage");
    ld = 1'b0; tick("R5 commit idle");
    rdy = 1'b1; tick("R6 run 1");
    fw = 32'h2000_0000; ld = 1'b1; tick("R6 load mid period");
    ld = 1'b0; tick("R6 old step");
    chk(sram_addr == 18'h30000, "R6 old step kept", sram_addr, 18'h30000);
    tick("R6 wrap");
    chk(sram_addr == 18'h00000, "R6 wrap uses old step", sram_addr, 0);
    tick("R6 new step");
    chk(sram_addr == 18'h08000, "R6 new step after wrap", sram_addr, 18'h08000);
    tick("R6 new step 2");
    chk(sram_addr == 18'h10000, "R6 new step continues", sram_addr, 18'h10000);
  endtask

  task automatic t_period();
    int wraps;
    logic [AW-1:0] prev;
    rdy = 1'b0; tick("R2 clear");
    fw = 32'h1000_0000; ld = 1'b1; tick("R5 stage");
    ld = 1'b0; tick("R5 commit");
    rdy = 1'b1;
    wraps = 0; prev = '0;
    for (int i = 0; i < 64; i++) begin
      tick("R9 period");
      if (sram_addr < prev) wraps++;
      prev = sram_addr;
    end
    chk(wraps == 4, "R9 wrap count", wraps, 4);
  endtask

  task automatic t_drop();
    rdy = 1'b0; tick("R2 drop clears");
    chk(sram_addr == '0 && !sram_req, "R2 drop while running", sram_addr, 0);
    repeat (3) tick("R2 drain");
  endtask

  initial begin
    #1;
    t_reset();
    t_idle();
    t_run();
    t_pause();
    t_grant();
    t_retune();
    t_period();
    t_drop();
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    #1_000_000;
    total++; bad++;
    $display("FAIL watchdog actual=hung expected=done");
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

endmodule